// File: doc/BRIEF.md
# FM Operator Envelope Generator

This block produces the 10-bit attenuation envelope for a single FM synthesis operator. It moves through five phases: attack, decay, sustain, release and off. A free-running envelope counter advances on a tick strobe. In a full synthesizer that strobe comes once every three output samples. On each tick the active phase may update the envelope by an increment. The increment is read from a packed 32-bit rate word for that phase. Each rate word holds a counter shift amount and eight 3-bit increment codes.

Key-on and key-off pulses start a note and end it. The rate words, the sustain level and the 7-bit total level come in on ports and are sampled every cycle. The block reports the current phase and the raw envelope. It also drives a total attenuation, which is the envelope plus the total level scaled by eight. A downstream sine and log stage consumes that sum.

Top module: `fm_env_gen`

## Requirements
- R1: While rst_n is low at a clock edge, the phase becomes off (code 0), the envelope becomes 1023 and the envelope counter becomes 0.
- R2: A key_on pulse sets the phase to attack (code 4) at the next edge and leaves the envelope unchanged. key_on takes priority over key_off.
- R3: A key_off pulse without key_on sets the phase to release (code 1) and leaves the envelope unchanged. When the phase is off, key_off has no effect.
- R4: The phases are coded release=1, sustain=2, decay=3 and attack=4, and each phase uses its own rate word. A rate word holds a shift amount s in bits 31:24. Code k sits in bits 3k+2:3k. The 16-bit counter c increments on every tick. On a tick, an active phase updates only when the low s bits of the incremented c are all zero (all of c is compared when s is 16 or more). The code index is (c >> s) & 7.
- R5: The increment is (1 << code) >> 1, so code 0 gives 0 and code 7 gives 64.
- R6: In attack, an enabled update adds floor(-(env+1) * inc / 16) to the envelope. If the result is 0 or below, the envelope becomes 0 and the phase becomes decay.
- R7: In decay, an enabled update adds inc and saturates at 1023. The phase becomes sustain when the unsaturated sum is at or above the sustain level.
- R8: In sustain, an enabled update adds inc and saturates at 1023. The phase stays sustain.
- R9: In release, an enabled update adds inc. When the sum reaches 1023 or more, the envelope becomes 1023 and the phase becomes off.
- R10: In the off phase, ticks do not change the envelope, which stays at 1023.
- R11: atten always equals tot_lvl * 8 + env, in the range 0 to 2039.
- R12: Without a tick, the envelope does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Envelope step strobe |
| key_on | input | 1 | Note start pulse |
| key_off | input | 1 | Note end pulse |
| rate_rel | input | 32 | Rate word for release |
| rate_sus | input | 32 | Rate word for sustain |
| rate_dec | input | 32 | Rate word for decay |
| rate_att | input | 32 | Rate word for attack |
| sus_lvl | input | 10 | Decay-to-sustain threshold |
| tot_lvl | input | 7 | Total level |
| phase | output | 3 | Current phase code |
| env | output | 10 | Envelope attenuation |
| atten | output | 11 | Total attenuation sum |

## Verification
Two situations are hard to reach with random rates: release running all the way to off, and sustain pinned at 1023. Reaching them takes many gated ticks, and a random key pulse usually cuts the run short. Directed sequences therefore load rate words with shift 0 and all codes at 7. Attack then collapses to 0 in one tick, a sustain level of 0 moves decay straight into sustain, and the next ticks saturate sustain and end release. A decay run with shift 2 and code 1 shows an update on only every fourth tick. Long random runs then cover mixed shifts, codes, sustain levels and key timing.

// File: rtl/fmeg_pkg.sv
// Shared types and constants for the operator envelope generator.
// Assumes a 32-bit rate word: shift in the top byte, eight 3-bit codes below.
package fmeg_pkg;
    localparam int RATE_W    = 32;
    localparam int SHIFT_W   = 8;
    localparam int CODE_W    = 3;
    localparam int NUM_CODES = 8;
    localparam int INC_W     = (1 << CODE_W) - 1;

    typedef enum logic [2:0] {
        PH_OFF = 3'd0,
        PH_REL = 3'd1,
        PH_SUS = 3'd2,
        PH_DEC = 3'd3,
        PH_ATT = 3'd4
    } phase_t;
endpackage

// File: rtl/fmeg_rate_pick.sv
// Chooses the rate word for the active phase. Decides whether the incremented
// counter value opens an update, and decodes the step increment.
// Assumes cnt_i is the counter value after this tick's increment.
module fmeg_rate_pick
    import fmeg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  phase_t              phase_i,
    input  logic [RATE_W-1:0]   rate_rel_i,
    input  logic [RATE_W-1:0]   rate_sus_i,
    input  logic [RATE_W-1:0]   rate_dec_i,
    input  logic [RATE_W-1:0]   rate_att_i,
    input  logic [CNT_W-1:0]    cnt_i,
    output logic                gate_o,
    output logic [INC_W-1:0]    inc_o
);
    logic [RATE_W-1:0]  word;
    logic [SHIFT_W-1:0] shamt;
    logic [CODE_W-1:0]  codes [NUM_CODES];
    logic [CNT_W-1:0]   low_mask;
    logic [2:0]         idx;

    // Select the rate word that belongs to the current phase.
    always_comb begin
        case (phase_i)
            PH_REL:  word = rate_rel_i;
            PH_SUS:  word = rate_sus_i;
            PH_DEC:  word = rate_dec_i;
            default: word = rate_att_i;
        endcase
    end

    assign shamt = word[RATE_W-1 -: SHIFT_W];

    for (genvar k = 0; k < NUM_CODES; k++) begin : g_code
        assign codes[k] = word[k*CODE_W +: CODE_W];
    end

    // An update is enabled when the low shamt bits of the counter are zero.
    assign low_mask = ~({CNT_W{1'b1}} << shamt);
    assign gate_o   = (cnt_i & low_mask) == '0;
    assign idx      = 3'(cnt_i >> shamt);
    assign inc_o    = INC_W'(((INC_W+1)'(1) << codes[idx]) >> 1);
endmodule

// File: rtl/fmeg_next.sv
// Combinational next-state step for one enabled envelope update.
// Assumes the caller applies the result only for an enabled tick in an active phase.
module fmeg_next
    import fmeg_pkg::*;
#(
    parameter int ENV_W = 10
) (
    input  phase_t              phase_i,
    input  logic [ENV_W-1:0]    env_i,
    input  logic [ENV_W-1:0]    sus_lvl_i,
    input  logic [INC_W-1:0]    inc_i,
    output phase_t              phase_o,
    output logic [ENV_W-1:0]    env_o
);
    localparam int AW = ENV_W + INC_W + 2;
    localparam logic [ENV_W:0] ENV_MAX = (ENV_W+1)'((1 << ENV_W) - 1);

    logic signed [AW-1:0] env_s, inv_s, prod_s, sum_s;
    logic [ENV_W:0]       wide, sat;

    assign env_s  = $signed(AW'(env_i));
    assign inv_s  = ~env_s;
    assign prod_s = inv_s * $signed(AW'(inc_i));
    assign sum_s  = env_s + (prod_s >>> 4);
    assign wide   = {1'b0, env_i} + (ENV_W+1)'(inc_i);
    assign sat    = (wide >= ENV_MAX) ? ENV_MAX : wide;

    // Apply the rule of the current phase.
    always_comb begin
        phase_o = phase_i;
        env_o   = env_i;
        case (phase_i)
            PH_ATT: begin
                if (sum_s <= 0) begin
                    env_o   = '0;
                    phase_o = PH_DEC;
                end else begin
                    env_o   = ENV_W'(sum_s);
                end
            end
            PH_DEC: begin
                env_o = ENV_W'(sat);
                if (wide >= {1'b0, sus_lvl_i}) phase_o = PH_SUS;
            end
            PH_SUS: env_o = ENV_W'(sat);
            PH_REL: begin
                env_o = ENV_W'(sat);
                if (wide >= ENV_MAX) phase_o = PH_OFF;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fm_env_gen.sv
// Envelope generator for one FM operator: phase register, envelope register and
// the shared step counter. Assumes key pulses last one cycle and that all rate
// and level inputs may change in any cycle.
module fm_env_gen
    import fmeg_pkg::*;
#(
    parameter int ENV_W = 10,
    parameter int TL_W  = 7,
    parameter int TL_SH = 3,
    parameter int CNT_W = 16,
    parameter int ATN_W = ((TL_W + TL_SH) > ENV_W ? (TL_W + TL_SH) : ENV_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              key_on,
    input  logic              key_off,
    input  logic [31:0]       rate_rel,
    input  logic [31:0]       rate_sus,
    input  logic [31:0]       rate_dec,
    input  logic [31:0]       rate_att,
    input  logic [ENV_W-1:0]  sus_lvl,
    input  logic [TL_W-1:0]   tot_lvl,
    output logic [2:0]        phase,
    output logic [ENV_W-1:0]  env,
    output logic [ATN_W-1:0]  atten
);
    localparam logic [ENV_W-1:0] ENV_MAX = {ENV_W{1'b1}};

    phase_t             phase_q, phase_nx;
    logic [ENV_W-1:0]   env_q, env_nx;
    logic [CNT_W-1:0]   cnt_q, cnt_nx;
    logic               gate;
    logic [INC_W-1:0]   inc;

    assign cnt_nx = cnt_q + 1'b1;

    fmeg_rate_pick #(.CNT_W(CNT_W)) u_pick (
        .phase_i    (phase_q),
        .rate_rel_i (rate_rel),
        .rate_sus_i (rate_sus),
        .rate_dec_i (rate_dec),
        .rate_att_i (rate_att),
        .cnt_i      (cnt_nx),
        .gate_o     (gate),
        .inc_o      (inc)
    );

    fmeg_next #(.ENV_W(ENV_W)) u_next (
        .phase_i   (phase_q),
        .env_i     (env_q),
        .sus_lvl_i (sus_lvl),
        .inc_i     (inc),
        .phase_o   (phase_nx),
        .env_o     (env_nx)
    );

    // Step counter: advances on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_nx;
    end

    // Phase and envelope: key pulses first, then enabled tick updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_OFF;
            env_q   <= ENV_MAX;
        end else if (key_on) begin
            phase_q <= PH_ATT;
        end else if (key_off && phase_q != PH_OFF) begin
            phase_q <= PH_REL;
        end else if (tick && gate && phase_q != PH_OFF) begin
            phase_q <= phase_nx;
            env_q   <= env_nx;
        end
    end

    assign phase = phase_q;
    assign env   = env_q;
    assign atten = (ATN_W'(tot_lvl) << TL_SH) + ATN_W'(env_q);
endmodule

// File: rtl/fmeg_chk.sv
// Property checker for fm_env_gen, attached by bind below.
module fmeg_chk #(
    parameter int ENV_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             key_on,
    input logic             key_off,
    input logic [2:0]       phase,
    input logic [ENV_W-1:0] env
);
    localparam logic [ENV_W-1:0] ENV_MAX = {ENV_W{1'b1}};

    p_keyon_att_r2: assert property (@(posedge clk) disable iff (!rst_n)
        key_on |=> phase == 3'd4);

    p_off_holds_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd0 |-> env == ENV_MAX);

    p_att_falls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd4 |=> env <= $past(env));

    p_dec_rises_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd3 |=> env >= $past(env));

    p_sus_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd2 && !key_on && !key_off) |=> phase == 3'd2);

    p_no_tick_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(env));

    p_phase_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= 3'd4);
endmodule

bind fm_env_gen fmeg_chk #(.ENV_W(ENV_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .key_on  (key_on),
    .key_off (key_off),
    .phase   (phase),
    .env     (env)
);

// File: tb/sim_fm_env_gen.sv
`timescale 1ns/1ps
module sim_fm_env_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, key_on = 1'b0, key_off = 1'b0;
    logic [31:0] rate_rel = '0, rate_sus = '0, rate_dec = '0, rate_att = '0;
    logic [9:0]  sus_lvl = '0;
    logic [6:0]  tot_lvl = 7'd5;
    logic [2:0]  phase;
    logic [9:0]  env;
    logic [10:0] atten;

    int total = 0, bad = 0;
    int m_env;
    int m_ph;
    logic [15:0] m_cnt;

    always #2.5 clk = ~clk;

    fm_env_gen u0 (.*);

    // Count one check; on mismatch print a FAIL line with the values.
    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Model one clock edge from the requirements.
    task automatic model(input bit tk, input bit ko, input bit kf);
        logic [15:0] cn;
        logic [31:0] w;
        int s, idx, code, inc, nv;
        bit g;
        cn = m_cnt + 16'd1;
        if (tk) m_cnt = cn;
        if (ko) m_ph = 4;
        else if (kf && m_ph != 0) m_ph = 1;
        else if (tk && m_ph != 0) begin
            w = (m_ph == 1) ? rate_rel : (m_ph == 2) ? rate_sus :
                (m_ph == 3) ? rate_dec : rate_att;
            s = int'(w[31:24]);
            g = 1;
            for (int i = 0; i < 16; i++) if (i < s && cn[i]) g = 0;
            if (g) begin
                idx  = (s >= 16) ? 0 : int'((cn >> s) & 16'd7);
                code = int'((w >> (3*idx)) & 32'd7);
                inc  = (1 << code) >> 1;
                case (m_ph)
                    4: begin
                        nv = m_env + ((-(m_env + 1) * inc) >>> 4);
                        if (nv <= 0) begin m_env = 0; m_ph = 3; end
                        else m_env = nv;
                    end
                    3: begin
                        nv = m_env + inc;
                        if (nv >= int'(sus_lvl)) m_ph = 2;
                        m_env = (nv > 1023) ? 1023 : nv;
                    end
                    2: begin
                        nv = m_env + inc;
                        m_env = (nv > 1023) ? 1023 : nv;
                    end
                    default: begin
                        nv = m_env + inc;
                        if (nv >= 1023) begin m_env = 1023; m_ph = 0; end
                        else m_env = nv;
                    end
                endcase
            end
        end
    endtask

    // Drive one cycle, advance the model, compare just after the edge.
    task automatic step(input bit tk, input bit ko, input bit kf, input string tag);
        string req;
        @(negedge clk);
        tick = tk; key_on = ko; key_off = kf;
        if (tag != "") req = tag;
        else if (ko) req = "R2";
        else if (kf) req = "R3";
        else if (!tk) req = "R12";
        else case (m_ph)
            0: req = "R10";
            1: req = "R9";
            2: req = "R8";
            3: req = "R7";
            default: req = "R6";
        endcase
        model(tk, ko, kf);
        @(posedge clk);
        #1;
        chk(req, "phase", int'(phase), m_ph);
        chk(req, "env", int'(env), m_env);
        chk("R11", "atten", int'(atten), int'(tot_lvl) * 8 + int'(env));
        key_on = 0; key_off = 0;
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(posedge clk);
        #1;
        m_ph = 0; m_env = 1023; m_cnt = '0;
        chk("R1", "phase", int'(phase), 0);
        chk("R1", "env", int'(env), 1023);
        chk("R1", "atten", int'(atten), 5*8 + 1023);
        @(negedge clk) rst_n = 1'b1;

        // key_off while off, ticks while off
        step(0, 0, 1, "R3");
        rate_rel = {8'd0, 24'hFFFFFF};
        repeat (3) step(1, 0, 0, "R10");
        // key_on beats key_off
        step(0, 1, 1, "R2");
        repeat (3) step(0, 0, 0, "R12");
        // code 0: no change in attack
        rate_att = 32'd0;
        repeat (2) step(1, 0, 0, "R5");
        // fast attack reaches 0 and moves to decay
        rate_att = {8'd0, 24'hFFFFFF};
        step(1, 0, 0, "R6");
        // decay gated by shift 2, code 1
        sus_lvl = 10'd1023;
        rate_dec = {8'd2, 24'h249249};
        repeat (12) step(1, 0, 0, "R4");
        // release to off
        step(0, 0, 1, "R3");
        repeat (20) step(1, 0, 0, "R9");
        // attack, decay straight into sustain, then saturate
        step(0, 1, 0, "R2");
        step(1, 0, 0, "R6");
        sus_lvl = 10'd0;
        rate_dec = {8'd0, 24'hFFFFFF};
        rate_sus = {8'd0, 24'hFFFFFF};
        step(1, 0, 0, "R7");
        repeat (20) step(1, 0, 0, "R8");
        tot_lvl = 7'd127;
        step(0, 0, 0, "R11");

        // random phase
        for (int n = 0; n < 30000; n++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 3) begin
                rate_att = {6'd0, 2'($urandom), 24'($urandom)};
                rate_dec = {6'd0, 2'($urandom), 24'($urandom)};
                rate_sus = {6'd0, 2'($urandom), 24'($urandom)};
                rate_rel = {6'd0, 2'($urandom), 24'($urandom)};
                sus_lvl  = 10'($urandom);
                tot_lvl  = 7'($urandom);
            end
            step(1'($urandom), r == 50, r == 60 || r == 61, "");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule